// File: doc/BRIEF.md
# Readout protection access controller

This block holds the stored protection byte and its complement and turns them into one of three protection levels. For every memory request it decides, in the same cycle, whether to grant the access or answer with a bus error and a hard-fault indication. The decision depends on the level and on the current boot or execution mode together. The modes are user flash boot, debug, RAM boot, bootloader and secure provisioning. The targets are the main array, the option bytes, the backup registers, the secondary SRAM and the system memory region.

The block also handles requests to rewrite the protection byte. A change from level 0 or level 1 is always accepted. Leaving level 2 needs a secure system and a secure master, so with a non-secure system level 2 is permanent. A drop to level 0 can pulse a mass-erase request while the write is presented. Each refused attempt to modify the option bytes at level 2 sets a sticky error flag in every status view, and those flags can raise an interrupt.

Top module: `rdp_access_ctrl`

## Requirements
- R1: The level comes from the stored byte and its complement. Byte 0xAA with complement 0x55 gives level 0, output code 0. Byte 0xCC with complement 0x33 gives level 2, code 2. Any other byte, or any complement that is not the bitwise inverse, gives level 1, code 1. Reset loads 0xFF/0xFF, so the block starts at level 1. An accepted write updates `level` on the next clock edge.
- R2: At level 0, every read (op 0), program (op 1) and erase (op 2) is granted on the main array (target 0), option bytes (1), backup registers (2) and secondary SRAM (3), in boot modes 0 to 4.
- R3: At level 1, user flash mode (mode 0) is granted everything. Debug (1), RAM boot (2), bootloader (3) and secure provisioning (4) are refused any access to the main array, backup registers and secondary SRAM, but may access the option bytes.
- R4: At level 2, `bootPermit` is low for debug, RAM boot and bootloader, and every access from those modes is refused. Secure provisioning is permitted unless `bootLock` is set, and when it is permitted it follows the level 1 non-user rules for the main array, backup registers and secondary SRAM. When `bootLock` is set, all of its accesses are refused. At levels 0 and 1, `bootPermit` is high for modes 0 to 4.
- R5: At level 2 in user mode, the main array, backup registers and secondary SRAM are granted all operations. Option-byte reads are granted. Option-byte program or erase is granted only when both `sysSecure` and `accSecure` are high. The same secure-only rule for option-byte modifies applies to secure provisioning when it is permitted.
- R6: A protection-byte write presented at level 0 or level 1 is always accepted. A non-0xCC value moves level 0 to level 1 (unless it is 0xAA/0x55), and 0xCC/0x33 moves level 0 or level 1 straight to level 2.
- R7: `eraseReq` is high in the cycle an accepted write would lower the level to 0, but only when `eraseOnRegress` is high. It stays low otherwise.
- R8: At level 2, a protection-byte write is refused unless both `sysSecure` and `accSecure` are high. A refused write leaves the level unchanged and sets the error flags.
- R9: The system memory region (target 4) grants reads at every level and in every mode, and refuses program and erase.
- R10: Every refused option-byte modify at level 2 and every refused protection-byte write sets all `errFlag` bits on the next edge. Each bit holds until a 1 is written to the matching `errClr` bit; a new set wins over a clear. `irq` is `irqEn` AND (the OR of the flags).
- R11: `dbgEn` is low while reset is asserted and whenever the level is 2, and high otherwise.
- R12: With `accValid` high, exactly one of `accGrant` and `accBusErr` is high, and `hardFault` equals `accBusErr`. With `accValid` low, all three are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bootMode | input | 3 | 0 user flash, 1 debug, 2 RAM boot, 3 bootloader, 4 secure provisioning |
| bootLock | input | 1 | Blocks secure-provisioning boot at level 2 |
| sysSecure | input | 1 | System-secure enable |
| accValid | input | 1 | Access request present |
| accTarget | input | 3 | 0 main, 1 option bytes, 2 backup registers, 3 secondary SRAM, 4 system memory |
| accOp | input | 2 | 0 read, 1 program, 2 erase |
| accSecure | input | 1 | Request comes from the secure master |
| accGrant | output | 1 | Access granted |
| accBusErr | output | 1 | Access refused with a bus error |
| hardFault | output | 1 | Hard-fault indication for a refused access |
| bootPermit | output | 1 | Current boot mode is allowed at this level |
| dbgEn | output | 1 | Debug port enable |
| rdpWrValid | input | 1 | Protection-byte write request |
| rdpWrByte | input | 8 | New protection byte |
| rdpWrCompl | input | 8 | Complement written with the byte |
| eraseOnRegress | input | 1 | Request a mass erase when the level drops to 0 |
| eraseReq | output | 1 | Mass-erase request |
| level | output | 2 | Current protection level |
| errClr | input | 2 | Write-1 clear for each error flag view |
| errFlag | output | 2 | Sticky write-protection error flags, one per view |
| irqEn | input | 1 | Interrupt enable for the error flags |
| irq | output | 1 | Write-protection error interrupt |

## Verification
The grant, bus error, hard fault, boot permission and erase request are combinational. The bench drives them at the falling edge and samples them 1 ns later, before the next rising edge. The level and the error flags are due one rising edge after the write or the refused access, so they are read at the following falling edge. The interrupt follows the flags in that same cycle. The bench sweeps every mode, target, operation, secure flag, system-secure flag and lock value at each of the three levels. It clears the flags between steps so that each refusal is seen on its own.

// File: rtl/rdp_pkg.sv
package rdp_pkg;

  typedef enum logic [1:0] {
    LVL0 = 2'd0,
    LVL1 = 2'd1,
    LVL2 = 2'd2
  } levelT;

  localparam logic [2:0] MODE_USER   = 3'd0;
  localparam logic [2:0] MODE_DEBUG  = 3'd1;
  localparam logic [2:0] MODE_RAM    = 3'd2;
  localparam logic [2:0] MODE_LOADER = 3'd3;
  localparam logic [2:0] MODE_PROV   = 3'd4;

  localparam logic [2:0] TGT_MAIN = 3'd0;
  localparam logic [2:0] TGT_OPT  = 3'd1;
  localparam logic [2:0] TGT_BKP  = 3'd2;
  localparam logic [2:0] TGT_SRAM = 3'd3;
  localparam logic [2:0] TGT_SYS  = 3'd4;

  localparam logic [1:0] OP_READ = 2'd0;

  localparam logic [7:0] CODE_OPEN   = 8'hAA;
  localparam logic [7:0] CODE_LOCKED = 8'hCC;

  typedef struct packed {
    logic loadLevel;
    logic setErr;
  } strobeT;

  function automatic levelT decodeLevel(input logic [7:0] b, input logic [7:0] c);
    if (c != ~b)            return LVL1;
    if (b == CODE_OPEN)     return LVL0;
    if (b == CODE_LOCKED)   return LVL2;
    return LVL1;
  endfunction

endpackage

// File: rtl/rdp_ctrl.sv
module rdp_ctrl
  import rdp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  levelT      level,
  input  logic [2:0] bootMode,
  input  logic       bootLock,
  input  logic       sysSecure,
  input  logic       accValid,
  input  logic [2:0] accTarget,
  input  logic [1:0] accOp,
  input  logic       accSecure,
  input  logic       rdpWrValid,
  input  logic [7:0] rdpWrByte,
  input  logic [7:0] rdpWrCompl,
  input  logic       eraseOnRegress,
  output logic       accGrant,
  output logic       accBusErr,
  output logic       bootPermit,
  output logic       eraseReq,
  output strobeT     strobes
);

  logic  isModify;
  logic  modeOk;
  logic  secureWrOk;
  logic  allow;
  logic  optReject;
  logic  wrAccept;
  levelT newLevel;

  always_comb begin
    isModify   = (accOp != OP_READ);
    secureWrOk = sysSecure && accSecure;
    if (level == LVL2)
      modeOk = (bootMode == MODE_USER) || (bootMode == MODE_PROV && !bootLock);
    else
      modeOk = 1'b1;
    bootPermit = modeOk && (bootMode <= MODE_PROV);

    if (accTarget == TGT_SYS)
      allow = !isModify;
    else if (accTarget > TGT_SYS)
      allow = 1'b0;
    else if (!bootPermit)
      allow = 1'b0;
    else if (level == LVL0)
      allow = 1'b1;
    else if (accTarget == TGT_OPT)
      allow = (level == LVL2 && isModify) ? secureWrOk : 1'b1;
    else
      allow = (bootMode == MODE_USER);

    accGrant  = accValid && allow;
    accBusErr = accValid && !allow;
    optReject = accValid && !allow && isModify &&
                (accTarget == TGT_OPT) && (level == LVL2);

    newLevel  = decodeLevel(rdpWrByte, rdpWrCompl);
    wrAccept  = rdpWrValid && ((level != LVL2) || secureWrOk);
    eraseReq  = wrAccept && eraseOnRegress && (newLevel == LVL0) && (level != LVL0);

    strobes.loadLevel = wrAccept;
    strobes.setErr    = optReject || (rdpWrValid && !wrAccept);
  end

  a_r12_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(accGrant && accBusErr));
  a_r12_answer: assert property (@(posedge clk) disable iff (!rstN)
    accValid |-> (accGrant || accBusErr));
  a_r9_sysmem_ro: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accTarget == TGT_SYS && accOp != OP_READ) |-> accBusErr);
  a_r7_erase_on_accept: assert property (@(posedge clk) disable iff (!rstN)
    eraseReq |-> (strobes.loadLevel && eraseOnRegress));
  a_r4_l2_debug_closed: assert property (@(posedge clk) disable iff (!rstN)
    (level == LVL2 && bootMode == MODE_DEBUG && accValid && accTarget != TGT_SYS) |-> accBusErr);

endmodule

// File: rtl/rdp_datapath.sv
module rdp_datapath
  import rdp_pkg::*;
#(
  parameter int         NUM_VIEWS   = 2,
  parameter logic [7:0] RESET_BYTE  = 8'hFF,
  parameter logic [7:0] RESET_COMPL = 8'hFF
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobeT               strobes,
  input  logic [7:0]           rdpWrByte,
  input  logic [7:0]           rdpWrCompl,
  input  logic                 sysSecure,
  input  logic [NUM_VIEWS-1:0] errClr,
  input  logic                 irqEn,
  output levelT                level,
  output logic [NUM_VIEWS-1:0] errFlag,
  output logic                 irq,
  output logic                 dbgEn
);

  logic [7:0] byteQ;
  logic [7:0] complQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteQ  <= RESET_BYTE;
      complQ <= RESET_COMPL;
    end else if (strobes.loadLevel) begin
      byteQ  <= rdpWrByte;
      complQ <= rdpWrCompl;
    end
  end

  assign level = decodeLevel(byteQ, complQ);
  assign dbgEn = rstN && (level != LVL2);

  for (genvar v = 0; v < NUM_VIEWS; v++) begin : g_view
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                errFlag[v] <= 1'b0;
      else if (strobes.setErr)  errFlag[v] <= 1'b1;
      else if (errClr[v])       errFlag[v] <= 1'b0;
    end
  end

  assign irq = irqEn && (|errFlag);

  a_r1_level_load: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadLevel |=> (level == decodeLevel($past(rdpWrByte), $past(rdpWrCompl))));
  a_r8_irreversible: assert property (@(posedge clk) disable iff (!rstN)
    (level == LVL2 && !sysSecure) |=> (level == LVL2));
  a_r10_flag_set: assert property (@(posedge clk) disable iff (!rstN)
    strobes.setErr |=> (&errFlag));
  a_r10_flag_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.setErr && errClr == '0) |=> $stable(errFlag));

endmodule

// File: rtl/rdp_access_ctrl.sv
module rdp_access_ctrl
  import rdp_pkg::*;
#(
  parameter int         NUM_VIEWS   = 2,
  parameter logic [7:0] RESET_BYTE  = 8'hFF,
  parameter logic [7:0] RESET_COMPL = 8'hFF
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [2:0]           bootMode,
  input  logic                 bootLock,
  input  logic                 sysSecure,
  input  logic                 accValid,
  input  logic [2:0]           accTarget,
  input  logic [1:0]           accOp,
  input  logic                 accSecure,
  output logic                 accGrant,
  output logic                 accBusErr,
  output logic                 hardFault,
  output logic                 bootPermit,
  output logic                 dbgEn,
  input  logic                 rdpWrValid,
  input  logic [7:0]           rdpWrByte,
  input  logic [7:0]           rdpWrCompl,
  input  logic                 eraseOnRegress,
  output logic                 eraseReq,
  output logic [1:0]           level,
  input  logic [NUM_VIEWS-1:0] errClr,
  output logic [NUM_VIEWS-1:0] errFlag,
  input  logic                 irqEn,
  output logic                 irq
);

  levelT  curLevel;
  strobeT strobes;

  rdp_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .level         (curLevel),
    .bootMode      (bootMode),
    .bootLock      (bootLock),
    .sysSecure     (sysSecure),
    .accValid      (accValid),
    .accTarget     (accTarget),
    .accOp         (accOp),
    .accSecure     (accSecure),
    .rdpWrValid    (rdpWrValid),
    .rdpWrByte     (rdpWrByte),
    .rdpWrCompl    (rdpWrCompl),
    .eraseOnRegress(eraseOnRegress),
    .accGrant      (accGrant),
    .accBusErr     (accBusErr),
    .bootPermit    (bootPermit),
    .eraseReq      (eraseReq),
    .strobes       (strobes)
  );

  rdp_datapath #(
    .NUM_VIEWS  (NUM_VIEWS),
    .RESET_BYTE (RESET_BYTE),
    .RESET_COMPL(RESET_COMPL)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .rdpWrByte (rdpWrByte),
    .rdpWrCompl(rdpWrCompl),
    .sysSecure (sysSecure),
    .errClr    (errClr),
    .irqEn     (irqEn),
    .level     (curLevel),
    .errFlag   (errFlag),
    .irq       (irq),
    .dbgEn     (dbgEn)
  );

  assign hardFault = accBusErr;
  assign level     = curLevel;

endmodule

// File: tb/rdp_access_ctrl_bench.sv
`timescale 1ns/1ps
module rdp_access_ctrl_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] bootMode = '0;
  logic       bootLock = 1'b0;
  logic       sysSecure = 1'b0;
  logic       accValid = 1'b0;
  logic [2:0] accTarget = '0;
  logic [1:0] accOp = '0;
  logic       accSecure = 1'b0;
  logic       accGrant, accBusErr, hardFault, bootPermit, dbgEn;
  logic       rdpWrValid = 1'b0;
  logic [7:0] rdpWrByte = '0;
  logic [7:0] rdpWrCompl = '0;
  logic       eraseOnRegress = 1'b0;
  logic       eraseReq;
  logic [1:0] level;
  logic [1:0] errClr = '0;
  logic [1:0] errFlag;
  logic       irqEn = 1'b0;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int expLevel = 1;

  always #2.5 clk = ~clk;

  rdp_access_ctrl u_rdp_access_ctrl (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit mGrant(int lvl, int mode, int tgt, int op, bit sec, bit ss, bit lock);
    bit modify = (op != 0);
    if (tgt == 4) return !modify;
    if (lvl == 2) begin
      if (mode == 1 || mode == 2 || mode == 3) return 0;
      if (mode == 4 && lock) return 0;
    end
    if (lvl == 0) return 1;
    if (tgt == 1) return (lvl == 2 && modify) ? (sec && ss) : 1'b1;
    return (mode == 0);
  endfunction

  function automatic bit mBoot(int lvl, int mode, bit lock);
    if (lvl != 2) return (mode <= 4);
    return (mode == 0) || (mode == 4 && !lock);
  endfunction

  task automatic clearFlags();
    @(negedge clk);
    errClr = 2'b11;
    @(negedge clk);
    errClr = 2'b00;
  endtask

  task automatic sweep(input int lvl);
    for (int mode = 0; mode < 5; mode++)
      for (int tgt = 0; tgt < 5; tgt++)
        for (int op = 0; op < 3; op++)
          for (int s = 0; s < 8; s++) begin
            bit sec  = s[0];
            bit ss   = s[1];
            bit lock = s[2];
            bit g    = mGrant(lvl, mode, tgt, op, sec, ss, lock);
            bit rej  = !g && (lvl == 2) && (tgt == 1) && (op != 0);
            string tag;
            tag = (tgt == 4) ? "R9" : (lvl == 0) ? "R2" : (lvl == 1) ? "R3" :
                  (mode == 0) ? "R5" : "R4";
            @(negedge clk);
            bootMode = 3'(mode); accTarget = 3'(tgt); accOp = 2'(op);
            accSecure = sec; sysSecure = ss; bootLock = lock; accValid = 1'b1;
            #1;
            chk({tag, " grant"}, int'(accGrant), int'(g));
            chk("R12 busErr", int'(accBusErr), int'(!g));
            chk("R12 hardFault", int'(hardFault), int'(!g));
            chk("R4 bootPermit", int'(bootPermit), int'(mBoot(lvl, mode, lock)));
            @(negedge clk);
            accValid = 1'b0;
            #1;
            chk("R12 idle", int'(accGrant | accBusErr | hardFault), 0);
            chk("R10 flag after access", int'(errFlag), rej ? 3 : 0);
            if (rej) clearFlags();
          end
  endtask

  task automatic rdpWrite(input logic [7:0] b, input logic [7:0] c, input bit sec,
                          input bit ss, input bit eor, input int nextLvl,
                          input bit expErase, input bit expErr, input string tag);
    @(negedge clk);
    rdpWrByte = b; rdpWrCompl = c; accSecure = sec; sysSecure = ss;
    eraseOnRegress = eor; rdpWrValid = 1'b1;
    #1;
    chk({tag, " eraseReq"}, int'(eraseReq), int'(expErase));
    chk({tag, " level before edge"}, int'(level), expLevel);
    @(negedge clk);
    rdpWrValid = 1'b0; eraseOnRegress = 1'b0;
    #1;
    chk({tag, " level"}, int'(level), nextLvl);
    chk({tag, " errFlag"}, int'(errFlag), expErr ? 3 : 0);
    chk("R7 erase idle", int'(eraseReq), 0);
    expLevel = nextLvl;
  endtask

  initial begin
    #3;
    chk("R11 dbgEn in reset", int'(dbgEn), 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R1 reset level", int'(level), 1);
    chk("R10 reset flags", int'(errFlag), 0);
    chk("R10 reset irq", int'(irq), 0);
    chk("R11 dbgEn at L1", int'(dbgEn), 1);

    sweep(1);
    rdpWrite(8'hAA, 8'h55, 0, 0, 1, 0, 1, 0, "R7 L1->L0 erase");
    chk("R11 dbgEn at L0", int'(dbgEn), 1);
    sweep(0);
    rdpWrite(8'h12, 8'hED, 0, 0, 1, 1, 0, 0, "R6 L0->L1");
    rdpWrite(8'hAA, 8'h55, 0, 0, 0, 0, 0, 0, "R7 no erase bit");
    rdpWrite(8'hCC, 8'h00, 0, 0, 0, 1, 0, 0, "R1 bad complement");
    rdpWrite(8'hAA, 8'h54, 0, 0, 1, 1, 0, 0, "R1 AA bad complement");
    rdpWrite(8'hAA, 8'h55, 0, 0, 0, 0, 0, 0, "R6 back to L0");
    rdpWrite(8'hAA, 8'h55, 0, 0, 1, 0, 0, 0, "R7 L0 stays no erase");
    rdpWrite(8'hCC, 8'h33, 0, 0, 0, 2, 0, 0, "R6 L0->L2");
    chk("R11 dbgEn at L2", int'(dbgEn), 0);
    sweep(2);

    rdpWrite(8'hAA, 8'h55, 1, 0, 1, 2, 0, 1, "R8 nonsecure system");
    @(negedge clk);
    irqEn = 1'b1;
    #1;
    chk("R10 irq enabled", int'(irq), 1);
    errClr = 2'b01;
    @(negedge clk);
    errClr = 2'b00;
    #1;
    chk("R10 clear view0", int'(errFlag), 2);
    chk("R10 irq one view", int'(irq), 1);
    irqEn = 1'b0;
    #1;
    chk("R10 irq disabled", int'(irq), 0);
    @(negedge clk);
    errClr = 2'b10;
    rdpWrValid = 1'b1; rdpWrByte = 8'h00; rdpWrCompl = 8'hFF;
    accSecure = 1'b0; sysSecure = 1'b0;
    @(negedge clk);
    errClr = 2'b00; rdpWrValid = 1'b0;
    #1;
    chk("R10 set beats clear", int'(errFlag), 3);
    chk("R8 level kept", int'(level), 2);
    clearFlags();
    #1;
    chk("R10 cleared", int'(errFlag), 0);
    rdpWrite(8'hAA, 8'h55, 0, 1, 1, 2, 0, 1, "R8 nonsecure master");
    clearFlags();
    rdpWrite(8'hAA, 8'h55, 1, 1, 1, 0, 1, 0, "R7 secure L2->L0");
    rdpWrite(8'h00, 8'hFF, 0, 0, 0, 1, 0, 0, "R6 L0->L1 any");
    rdpWrite(8'hCC, 8'h33, 0, 0, 0, 2, 0, 0, "R6 L1->L2");
    rdpWrite(8'h5A, 8'hA5, 1, 1, 1, 1, 0, 0, "R8 secure L2->L1");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule